// File: doc/BRIEF.md
# Instruction-Count Thread Fetch Selector

This block chooses, every cycle, which two hardware thread contexts are given the instruction fetch unit of a multithreaded core. Each of the eight contexts has a counter of its instructions that are in flight between decode and issue. The counter goes up by the number of instructions that enter decode and goes down by the number that leave the instruction queue.

The selection favours the contexts that hold the fewest instructions in the front end. Fast-moving threads keep the queue supplied, and a thread that is blocked behind long-latency work does not fill it. A context waiting on an instruction-cache miss cannot be chosen. The instruction cache banks are single-ported, so the second pick must map to a different bank from the first. A candidate that would conflict is passed over in favour of the next-best one.

Both picks are combinational functions of the registered counters and of the current stall flags and bank indices. A count update is therefore reflected in the selection in the cycle after its pulse.

Top module: `icount_fetch_sel`

## Requirements
- R1: After reset every counter is zero. With no stalls and all banks distinct, the first pick is thread 0 and the second pick is thread 1, both valid.
- R2: When both picks are valid, they name two different threads.
- R3: A thread whose stall bit is set is never picked.
- R4: The first pick is the eligible thread with the smallest count. The second pick is the eligible thread with the smallest count among those left.
- R5: A pulse on `inc_vld_i[t]` adds `inc_cnt_i[t*4 +: 4]` to thread t's counter at the next clock edge.
- R6: A pulse on `dec_vld_i[t]` subtracts `dec_cnt_i[t*4 +: 4]` from thread t's counter. An increment and a decrement in the same cycle are both applied, as one net change.
- R7: When counts are equal, the lower thread index wins.
- R8: A counter saturates at its maximum of 63 and does not wrap.
- R9: A counter stops at zero and does not wrap below it.
- R10: The second pick never uses the same bank as the first, where thread t's bank is `bank_i[t*3 +: 3]`. A conflicting thread is skipped even when its count is lower.
- R11: When no thread is eligible, both valid bits are low. When only one thread can be picked, the second valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_vld_i | input | 8 | Per-thread increment pulse |
| inc_cnt_i | input | 32 | Per-thread increment amount, 4 bits each |
| dec_vld_i | input | 8 | Per-thread decrement pulse |
| dec_cnt_i | input | 32 | Per-thread decrement amount, 4 bits each |
| stall_i | input | 8 | Per-thread instruction-cache miss stall |
| bank_i | input | 24 | Per-thread target cache bank, 3 bits each |
| sel0_id_o | output | 3 | First selected thread |
| sel0_vld_o | output | 1 | First selection valid |
| sel1_id_o | output | 3 | Second selected thread |
| sel1_vld_o | output | 1 | Second selection valid |

## Verification
Increment and decrement pulses for the same thread can arrive in the same cycle. The bench provokes this by pulsing both on one context at once, 5 in and 2 out. It then judges the result through the picks, against rival threads whose counts are chosen so that the net result of 3, increment alone (5) and decrement alone (0) each produce a different pair of picks. Saturation and the zero floor are judged the same way: a rival count is placed just below or just above the value the clamp must produce.

// File: rtl/icount_pkg.sv
package icount_pkg;
  parameter int unsigned IC_THREADS = 8;
  parameter int unsigned IC_CNT_W   = 6;
  parameter int unsigned IC_DELTA_W = 4;
  parameter int unsigned IC_BANK_W  = 3;

  function automatic int unsigned clamp_cnt(input int signed v, input int unsigned maxv);
    if (v < 0) return 0;
    if (v > int'(maxv)) return maxv;
    return int'(v);
  endfunction
endpackage

// File: rtl/icount_counter.sv
module icount_counter import icount_pkg::*; #(
  parameter int unsigned CNT_W   = IC_CNT_W,
  parameter int unsigned DELTA_W = IC_DELTA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_vld_i,
  input  logic [DELTA_W-1:0] inc_cnt_i,
  input  logic               dec_vld_i,
  input  logic [DELTA_W-1:0] dec_cnt_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned CntMax = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    int signed net;
    net = int'(cnt_q);
    if (inc_vld_i) net = net + int'(inc_cnt_i);
    if (dec_vld_i) net = net - int'(dec_cnt_i);
    cnt_d = CNT_W'(clamp_cnt(net, CntMax));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icount_picker.sv
module icount_picker #(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 6,
  localparam int unsigned IdW  = $clog2(N)
) (
  input  logic [N-1:0]       elig_i,
  input  logic [N*CNT_W-1:0] cnt_i,
  output logic [IdW-1:0]     id_o,
  output logic               vld_o
);
  logic [CNT_W-1:0] best;

  // strict less-than keeps the lower index on ties
  always_comb begin
    vld_o = 1'b0;
    id_o  = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!vld_o || cnt_i[i*CNT_W +: CNT_W] < best)) begin
        vld_o = 1'b1;
        id_o  = IdW'(i);
        best  = cnt_i[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel import icount_pkg::*; #(
  parameter int unsigned N       = IC_THREADS,
  parameter int unsigned CNT_W   = IC_CNT_W,
  parameter int unsigned DELTA_W = IC_DELTA_W,
  parameter int unsigned BANK_W  = IC_BANK_W,
  localparam int unsigned IdW    = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         inc_vld_i,
  input  logic [N*DELTA_W-1:0] inc_cnt_i,
  input  logic [N-1:0]         dec_vld_i,
  input  logic [N*DELTA_W-1:0] dec_cnt_i,
  input  logic [N-1:0]         stall_i,
  input  logic [N*BANK_W-1:0]  bank_i,
  output logic [IdW-1:0]       sel0_id_o,
  output logic                 sel0_vld_o,
  output logic [IdW-1:0]       sel1_id_o,
  output logic                 sel1_vld_o
);
  logic [N*CNT_W-1:0] cnt;
  logic [N-1:0]       elig0, elig1;
  logic [BANK_W-1:0]  bank0;

  for (genvar t = 0; t < N; t++) begin : g_cnt
    icount_counter #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_vld_i (inc_vld_i[t]),
      .inc_cnt_i (inc_cnt_i[t*DELTA_W +: DELTA_W]),
      .dec_vld_i (dec_vld_i[t]),
      .dec_cnt_i (dec_cnt_i[t*DELTA_W +: DELTA_W]),
      .cnt_o     (cnt[t*CNT_W +: CNT_W])
    );
  end

  assign elig0 = ~stall_i;

  icount_picker #(.N(N), .CNT_W(CNT_W)) u_pick0 (
    .elig_i (elig0),
    .cnt_i  (cnt),
    .id_o   (sel0_id_o),
    .vld_o  (sel0_vld_o)
  );

  assign bank0 = bank_i[sel0_id_o*BANK_W +: BANK_W];

  // second pick: drop the winner and every thread sharing its bank
  for (genvar t = 0; t < N; t++) begin : g_mask
    assign elig1[t] = elig0[t] && sel0_vld_o && (IdW'(t) != sel0_id_o)
                      && (bank_i[t*BANK_W +: BANK_W] != bank0);
  end

  icount_picker #(.N(N), .CNT_W(CNT_W)) u_pick1 (
    .elig_i (elig1),
    .cnt_i  (cnt),
    .id_o   (sel1_id_o),
    .vld_o  (sel1_vld_o)
  );
endmodule

// File: rtl/icount_fetch_sel_chk.sv
module icount_fetch_sel_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned IdW   = $clog2(N)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0]        stall_i,
  input logic [N*BANK_W-1:0] bank_i,
  input logic [IdW-1:0]      sel0_id_o,
  input logic                sel0_vld_o,
  input logic [IdW-1:0]      sel1_id_o,
  input logic                sel1_vld_o
);
  p_distinct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel1_vld_o |-> (sel0_vld_o && sel0_id_o != sel1_id_o));

  p_no_stall0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel0_vld_o |-> !stall_i[sel0_id_o]);

  p_no_stall1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel1_vld_o |-> !stall_i[sel1_id_o]);

  p_bank_split_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel1_vld_o |-> (bank_i[sel0_id_o*BANK_W +: BANK_W] != bank_i[sel1_id_o*BANK_W +: BANK_W]));

  p_first_when_any_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i != '1) |-> sel0_vld_o);

  p_none_when_all_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i == '1) |-> (!sel0_vld_o && !sel1_vld_o));
endmodule

bind icount_fetch_sel icount_fetch_sel_chk #(.N(N), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .bank_i     (bank_i),
  .sel0_id_o  (sel0_id_o),
  .sel0_vld_o (sel0_vld_o),
  .sel1_id_o  (sel1_id_o),
  .sel1_vld_o (sel1_vld_o)
);

// File: tb/icount_fetch_sel_tb.sv
`timescale 1ns/1ps
module icount_fetch_sel_tb;
  localparam int N = 8, DW = 4, BW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  inc_vld, dec_vld, stall;
  logic [N*DW-1:0] inc_cnt, dec_cnt;
  logic [N*BW-1:0] bank;
  logic [2:0]    s0_id, s1_id;
  logic          s0_v, s1_v;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  icount_fetch_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .inc_vld_i(inc_vld), .inc_cnt_i(inc_cnt),
    .dec_vld_i(dec_vld), .dec_cnt_i(dec_cnt),
    .stall_i(stall), .bank_i(bank),
    .sel0_id_o(s0_id), .sel0_vld_o(s0_v),
    .sel1_id_o(s1_id), .sel1_vld_o(s1_v)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected picks; vld=0 means id is not compared
  task automatic chk_sel(string req, int v0, int i0, int v1, int i1);
    #1;
    chk({req, " sel0_vld"}, int'(s0_v), v0);
    if (v0 != 0) chk({req, " sel0_id"}, int'(s0_id), i0);
    chk({req, " sel1_vld"}, int'(s1_v), v1);
    if (v1 != 0) chk({req, " sel1_id"}, int'(s1_id), i1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; inc_vld = '0; dec_vld = '0; inc_cnt = '0; dec_cnt = '0;
    stall = '0;
    for (int t = 0; t < N; t++) bank[t*BW +: BW] = BW'(t);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(int t, int inc, int dec);
    inc_vld[t] = (inc > 0); inc_cnt[t*DW +: DW] = DW'(inc);
    dec_vld[t] = (dec > 0); dec_cnt[t*DW +: DW] = DW'(dec);
    @(negedge clk);
    inc_vld = '0; dec_vld = '0;
  endtask

  task automatic only(logic [N-1:0] en);
    stall = ~en;
  endtask

  task automatic t_reset();
    do_reset();
    chk_sel("R1 reset picks", 1, 0, 1, 1);
  endtask

  task automatic t_order();
    do_reset();
    pulse(0, 4, 0); pulse(1, 2, 0); pulse(2, 1, 0);
    only(8'b0000_0111);
    chk_sel("R4 R5 fewest first", 1, 2, 1, 1);
    pulse(2, 3, 0); // t0=4 t1=2 t2=4
    chk_sel("R7 tie lower index", 1, 1, 1, 0);
  endtask

  task automatic t_stall();
    do_reset();
    stall = 8'b0000_0011;
    chk_sel("R3 stalled skipped", 1, 2, 1, 3);
    only(8'b0010_0000);
    chk_sel("R11 single eligible", 1, 5, 0, 0);
    stall = '1;
    chk_sel("R11 none eligible", 0, 0, 0, 0);
  endtask

  task automatic t_bank();
    do_reset();
    bank = '0; bank[5*BW +: BW] = 3'd1;
    pulse(5, 9, 0);
    chk_sel("R10 conflict skipped", 1, 0, 1, 5);
    bank = '0;
    chk_sel("R10 all same bank", 1, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    pulse(1, 3, 0); pulse(2, 2, 0);
    pulse(0, 5, 2); // net 3
    only(8'b0000_0111);
    chk_sel("R6 inc and dec together", 1, 2, 1, 0);
    pulse(0, 0, 3); // t0 = 0
    chk_sel("R6 decrement", 1, 0, 1, 2);
  endtask

  task automatic t_sat();
    do_reset();
    for (int k = 0; k < 5; k++) pulse(0, 15, 0); // 75 -> 63
    for (int k = 0; k < 4; k++) pulse(1, 15, 0);
    pulse(1, 2, 0); // t1 = 62
    only(8'b0000_0011);
    chk_sel("R8 saturate", 1, 1, 1, 0);
  endtask

  task automatic t_floor();
    do_reset();
    pulse(0, 2, 0); pulse(1, 1, 0);
    pulse(0, 0, 5); // 2-5 -> 0
    only(8'b0000_0011);
    chk_sel("R9 floor zero", 1, 0, 1, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    inc_vld = '0; dec_vld = '0; inc_cnt = '0; dec_cnt = '0; stall = '0; bank = '0;
    t_reset();
    t_order();
    t_stall();
    t_bank();
    t_same_cycle();
    t_sat();
    t_floor();
    chk("R2 distinct picks", int'(s0_id != s1_id || !s1_v), 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule